// File: doc/BRIEF.md
# FIFO threshold interrupt unit

This block holds two byte queues for a serial bus controller. The transmit queue is filled by the host and drained by the bus engine. The receive queue is filled by the bus engine and drained by the host. Each queue has its own enable and its own trigger level. When a queue is disabled, it is flushed and held empty.

An interrupt status register sits beside the queues and collects seven sources:

- the transmit queue running low;
- the receive queue filling up;
- a push into a full queue or a pop from an empty queue, on either side;
- a trailing-data timeout, for received bytes that sit below the trigger level for a programmed number of idle cycles.

Status bits are sticky and are acknowledged by writing ones. Each source has an enable bit, and the interrupt line is asserted while any enabled bit is pending. Queue levels and full/empty flags are packed into one status word for the host. The queue depth is a parameter, meant to be 16 or 64.

Top module: `fifo_irq_unit`

## Requirements
- R1: After reset both queues are empty, `fifo_sts_o` reads 0x0100_0100, and `irq_sts_o` and `irq_o` are 0.
- R2: Each queue returns bytes in push order. Its level counts the stored bytes, its full flag is set at DEPTH entries, and its empty flag is set at zero entries. Read data is valid while the queue is not empty, with no pop latency.
- R3: `ctrl_i` bit 0 enables the receive queue and bit 1 enables the transmit queue. While a queue is disabled, its contents are flushed at each clock, its push and pop strobes are ignored, and it raises no overrun or underrun.
- R4: A push into a full, enabled queue drops the byte and leaves the level and contents unchanged. On the next clock it sets status bit 3 (transmit) or bit 5 (receive).
- R5: A pop from an empty, enabled queue leaves the level at 0. On the next clock it sets status bit 2 (transmit) or bit 4 (receive).
- R6: Status bit 0 is set on every clock at which the transmit queue is enabled and its level is at or below the transmit trigger, `ctrl_i[22:16]`.
- R7: Status bit 1 is set on every clock at which the receive queue is enabled and its level is at or at or above the receive trigger, `ctrl_i[10:4]`.
- R8: Let T be the value of `trail_lim_i`. When the receive level stays between 1 and the trigger minus 1 with no receive push or pop, status bit 6 is set on the (T+1)th clock after the last push or pop.
- R9: A write with `sts_wr_i` high clears each status bit whose `sts_wdata_i` bit is 1 and leaves bits written 0 unchanged. A source that is active on the same clock keeps its bit set.
- R10: `irq_o` is high exactly when some status bit is set and its enable bit in `irq_en_i` (same bit position) is 1.
- R11: `fifo_sts_o` packs its fields as follows: transmit level in [6:0], transmit full at [7], transmit empty at [8], receive level in [22:16], receive full at [23], receive empty at [24]. All other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 32 | Queue enables and trigger levels |
| trail_lim_i | input | 4 | Idle cycles before the trailing interrupt |
| irq_en_i | input | 7 | Per-source interrupt enables |
| sts_wr_i | input | 1 | Status acknowledge strobe |
| sts_wdata_i | input | 7 | Write-one-to-clear mask |
| tx_push_i | input | 1 | Host push into the transmit queue |
| tx_data_i | input | 8 | Host transmit byte |
| rx_pop_i | input | 1 | Host pop from the receive queue |
| rx_data_o | output | 8 | Head of the receive queue |
| bus_tx_pop_i | input | 1 | Bus engine pop from the transmit queue |
| bus_tx_data_o | output | 8 | Head of the transmit queue |
| bus_rx_push_i | input | 1 | Bus engine push into the receive queue |
| bus_rx_data_i | input | 8 | Received byte from the bus engine |
| fifo_sts_o | output | 32 | Packed levels and flags |
| irq_sts_o | output | 7 | Pending interrupt status |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH = 16. At that depth, either queue reaches full in sixteen pushes, so overrun, the full flag and a complete drain all fit in a short run. The trailing limit is set to 4 so the idle window can be checked on both sides of its edge. The trigger levels are 2 (transmit) and 4 (receive), which lets both the below-trigger trailing case and the at-trigger almost-full case occur within a few bytes.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int unsigned STS_W  = 7;
  localparam int unsigned LVL_FW = 7;

  localparam int unsigned BIT_TX_AE  = 0;
  localparam int unsigned BIT_RX_AF  = 1;
  localparam int unsigned BIT_TX_UNR = 2;
  localparam int unsigned BIT_TX_OVR = 3;
  localparam int unsigned BIT_RX_UNR = 4;
  localparam int unsigned BIT_RX_OVR = 5;
  localparam int unsigned BIT_TRAIL  = 6;

  typedef struct packed {
    logic              rx_en;
    logic              tx_en;
    logic [LVL_FW-1:0] rx_trig;
    logic [LVL_FW-1:0] tx_trig;
  } fifo_ctl_t;

  function automatic fifo_ctl_t decode_ctl(input logic [31:0] w);
    fifo_ctl_t c;
    c.rx_en   = w[0];
    c.tx_en   = w[1];
    c.rx_trig = w[10:4];
    c.tx_trig = w[22:16];
    return c;
  endfunction
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       push_i,
  input  logic [DW-1:0]              data_i,
  input  logic                       pop_i,
  output logic [DW-1:0]              data_o,
  output logic [$clog2(DEPTH):0]     level_o,
  output logic                       full_o,
  output logic                       empty_o,
  output logic                       ovr_o,
  output logic                       unr_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned LW = AW + 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [LW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == LW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = en_i & push_i & ~full_o;
  assign do_pop  = en_i & pop_i & ~empty_o;
  assign ovr_o   = en_i & push_i & full_o;
  assign unr_o   = en_i & pop_i & empty_o;
  assign level_o = cnt_q;
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (!en_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (!do_push && do_pop) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/trail_timer.sv
module trail_timer #(
  parameter int unsigned LW  = 5,
  parameter int unsigned TW  = 7,
  parameter int unsigned CW  = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] level_i,
  input  logic [TW-1:0] trig_i,
  input  logic          act_i,
  input  logic [CW-1:0] lim_i,
  output logic          fire_o
);
  logic [TW-1:0] lvl;
  logic [CW:0]   cnt_q;
  logic          arm;

  assign lvl    = TW'(level_i);
  assign arm    = (lvl != '0) && (lvl < trig_i);
  assign fire_o = arm && !act_i && (cnt_q == {1'b0, lim_i});

  // saturates one past the limit so the event fires once per idle stretch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (act_i || !arm)          cnt_q <= '0;
    else if (cnt_q <= {1'b0, lim_i}) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] sts_o,
  output logic         irq_o
);
  logic [N-1:0] sts_q, clr;

  assign clr = clr_wr_i ? clr_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~clr) | set_i;
  end

  assign sts_o = sts_q;
  assign irq_o = |(sts_q & en_i);
endmodule

// File: rtl/fifo_irq_unit.sv
module fifo_irq_unit
  import fifo_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] ctrl_i,
  input  logic [3:0]  trail_lim_i,
  input  logic [6:0]  irq_en_i,
  input  logic        sts_wr_i,
  input  logic [6:0]  sts_wdata_i,
  input  logic        tx_push_i,
  input  logic [7:0]  tx_data_i,
  input  logic        rx_pop_i,
  output logic [7:0]  rx_data_o,
  input  logic        bus_tx_pop_i,
  output logic [7:0]  bus_tx_data_o,
  input  logic        bus_rx_push_i,
  input  logic [7:0]  bus_rx_data_i,
  output logic [31:0] fifo_sts_o,
  output logic [6:0]  irq_sts_o,
  output logic        irq_o
);
  localparam int unsigned LW = $clog2(DEPTH) + 1;

  fifo_ctl_t         ctl;
  logic [LW-1:0]     tx_lvl, rx_lvl;
  logic [LVL_FW-1:0] tx_lvl7, rx_lvl7;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              tx_ovr, tx_unr, rx_ovr, rx_unr, trail_fire;
  logic [STS_W-1:0]  set_vec;

  assign ctl = decode_ctl(ctrl_i);

  byte_fifo #(.DEPTH(DEPTH), .DW(8)) i_tx_fifo (
    .clk_i, .rst_ni,
    .en_i   (ctl.tx_en),
    .push_i (tx_push_i),
    .data_i (tx_data_i),
    .pop_i  (bus_tx_pop_i),
    .data_o (bus_tx_data_o),
    .level_o(tx_lvl),
    .full_o (tx_full),
    .empty_o(tx_empty),
    .ovr_o  (tx_ovr),
    .unr_o  (tx_unr)
  );

  byte_fifo #(.DEPTH(DEPTH), .DW(8)) i_rx_fifo (
    .clk_i, .rst_ni,
    .en_i   (ctl.rx_en),
    .push_i (bus_rx_push_i),
    .data_i (bus_rx_data_i),
    .pop_i  (rx_pop_i),
    .data_o (rx_data_o),
    .level_o(rx_lvl),
    .full_o (rx_full),
    .empty_o(rx_empty),
    .ovr_o  (rx_ovr),
    .unr_o  (rx_unr)
  );

  trail_timer #(.LW(LW), .TW(LVL_FW), .CW(4)) i_trail (
    .clk_i, .rst_ni,
    .level_i(rx_lvl),
    .trig_i (ctl.rx_trig),
    .act_i  (ctl.rx_en & (bus_rx_push_i | rx_pop_i)),
    .lim_i  (trail_lim_i),
    .fire_o (trail_fire)
  );

  assign tx_lvl7 = LVL_FW'(tx_lvl);
  assign rx_lvl7 = LVL_FW'(rx_lvl);

  always_comb begin
    set_vec             = '0;
    set_vec[BIT_TX_AE]  = ctl.tx_en && (tx_lvl7 <= ctl.tx_trig);
    set_vec[BIT_RX_AF]  = ctl.rx_en && (rx_lvl7 >= ctl.rx_trig);
    set_vec[BIT_TX_UNR] = tx_unr;
    set_vec[BIT_TX_OVR] = tx_ovr;
    set_vec[BIT_RX_UNR] = rx_unr;
    set_vec[BIT_RX_OVR] = rx_ovr;
    set_vec[BIT_TRAIL]  = trail_fire;
  end

  irq_status #(.N(STS_W)) i_sts (
    .clk_i, .rst_ni,
    .set_i   (set_vec),
    .clr_wr_i(sts_wr_i),
    .clr_i   (sts_wdata_i),
    .en_i    (irq_en_i),
    .sts_o   (irq_sts_o),
    .irq_o   (irq_o)
  );

  assign fifo_sts_o = {7'b0, rx_empty, rx_full, rx_lvl7,
                       7'b0, tx_empty, tx_full, tx_lvl7};
endmodule

// File: rtl/fifo_irq_chk.sv
module fifo_irq_chk #(
  parameter int unsigned DEPTH = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_en_i,
  input logic       rx_en_i,
  input logic [6:0] tx_trig_i,
  input logic       tx_push_i,
  input logic       bus_tx_pop_i,
  input logic       rx_pop_i,
  input logic       sts_wr_i,
  input logic       clr_ovr_i,
  input logic [6:0] tx_lvl_i,
  input logic       tx_full_i,
  input logic       tx_empty_i,
  input logic       rx_empty_i,
  input logic       sts_ae_i,
  input logic       sts_tx_ovr_i,
  input logic       sts_rx_unr_i
);
  a_r2_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_full_i && tx_empty_i));

  a_r3_tx_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> (tx_empty_i && tx_lvl_i == 7'd0));

  a_r4_tx_overrun_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && tx_push_i && tx_full_i) |=> sts_tx_ovr_i);

  a_r4_tx_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && tx_push_i && tx_full_i && !bus_tx_pop_i) |=> (tx_lvl_i == 7'(DEPTH)));

  a_r5_rx_underrun_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i && rx_pop_i && rx_empty_i) |=> sts_rx_unr_i);

  a_r6_tx_almost_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && tx_lvl_i <= tx_trig_i) |=> sts_ae_i);

  a_r9_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr_i && clr_ovr_i && !(tx_en_i && tx_push_i && tx_full_i)) |=> !sts_tx_ovr_i);
endmodule

bind fifo_irq_unit fifo_irq_chk #(.DEPTH(DEPTH)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_en_i     (ctrl_i[1]),
  .rx_en_i     (ctrl_i[0]),
  .tx_trig_i   (ctrl_i[22:16]),
  .tx_push_i   (tx_push_i),
  .bus_tx_pop_i(bus_tx_pop_i),
  .rx_pop_i    (rx_pop_i),
  .sts_wr_i    (sts_wr_i),
  .clr_ovr_i   (sts_wdata_i[3]),
  .tx_lvl_i    (fifo_sts_o[6:0]),
  .tx_full_i   (fifo_sts_o[7]),
  .tx_empty_i  (fifo_sts_o[8]),
  .rx_empty_i  (fifo_sts_o[24]),
  .sts_ae_i    (irq_sts_o[0]),
  .sts_tx_ovr_i(irq_sts_o[3]),
  .sts_rx_unr_i(irq_sts_o[4])
);

// File: tb/test_fifo_irq_unit.sv
module test_fifo_irq_unit;
  localparam int unsigned DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ctrl_i = '0;
  logic [3:0]  trail_lim_i = 4'hF;
  logic [6:0]  irq_en_i = '0;
  logic        sts_wr_i = 1'b0;
  logic [6:0]  sts_wdata_i = '0;
  logic        tx_push_i = 1'b0;
  logic [7:0]  tx_data_i = '0;
  logic        rx_pop_i = 1'b0;
  logic [7:0]  rx_data_o;
  logic        bus_tx_pop_i = 1'b0;
  logic [7:0]  bus_tx_data_o;
  logic        bus_rx_push_i = 1'b0;
  logic [7:0]  bus_rx_data_i = '0;
  logic [31:0] fifo_sts_o;
  logic [6:0]  irq_sts_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];

  always #4 clk = ~clk;

  fifo_irq_unit #(.DEPTH(DEPTH)) i_fifo_irq_unit (
    .clk_i(clk), .rst_ni, .ctrl_i, .trail_lim_i, .irq_en_i, .sts_wr_i, .sts_wdata_i,
    .tx_push_i, .tx_data_i, .rx_pop_i, .rx_data_o, .bus_tx_pop_i, .bus_tx_data_o,
    .bus_rx_push_i, .bus_rx_data_i, .fifo_sts_o, .irq_sts_o, .irq_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side: record what the queue should hold
  task automatic tx_push(input logic [7:0] b);
    if (ctrl_i[1] && !fifo_sts_o[7]) tx_q.push_back(b);
    tx_data_i = b; tx_push_i = 1'b1;
    @(negedge clk);
    tx_push_i = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    if (ctrl_i[0] && !fifo_sts_o[23]) rx_q.push_back(b);
    bus_rx_data_i = b; bus_rx_push_i = 1'b1;
    @(negedge clk);
    bus_rx_push_i = 1'b0;
  endtask

  // monitor side: compare head of queue against the expected order
  task automatic tx_pop();
    if (tx_q.size() > 0) chk("R2 tx order", {24'b0, bus_tx_data_o}, {24'b0, tx_q.pop_front()});
    bus_tx_pop_i = 1'b1;
    @(negedge clk);
    bus_tx_pop_i = 1'b0;
  endtask

  task automatic rx_pop();
    if (rx_q.size() > 0) chk("R2 rx order", {24'b0, rx_data_o}, {24'b0, rx_q.pop_front()});
    rx_pop_i = 1'b1;
    @(negedge clk);
    rx_pop_i = 1'b0;
  endtask

  task automatic w1c(input logic [6:0] m);
    sts_wdata_i = m; sts_wr_i = 1'b1;
    @(negedge clk);
    sts_wr_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);
    chk("R1 fifo_sts", fifo_sts_o, 32'h0100_0100);
    chk("R1 irq_sts", {25'b0, irq_sts_o}, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);

    ctrl_i = 32'h0002_0043;  // rx trig 4, tx trig 2, both enabled
    trail_lim_i = 4'd4;
    step(1);
    chk("R6 tx almost-empty", {31'b0, irq_sts_o[0]}, 32'h1);
    chk("R10 masked irq", {31'b0, irq_o}, 32'h0);

    for (int i = 0; i < 5; i++) tx_push(8'h11 + 8'(i));
    chk("R11 tx fields", {23'b0, fifo_sts_o[8:0]}, 32'h005);
    w1c(7'h01);
    chk("R9 clear inactive bit", {31'b0, irq_sts_o[0]}, 32'h0);
    for (int i = 0; i < 5; i++) tx_pop();
    chk("R2 tx empty", {23'b0, fifo_sts_o[8:0]}, 32'h100);

    for (int i = 0; i < DEPTH; i++) tx_push(8'hA0 + 8'(i));
    chk("R2 tx full", {23'b0, fifo_sts_o[8:0]}, 32'h090);
    tx_push(8'hEE);
    chk("R4 tx overrun flag", {31'b0, irq_sts_o[3]}, 32'h1);
    chk("R4 tx level held", {25'b0, fifo_sts_o[6:0]}, DEPTH);
    for (int i = 0; i < DEPTH; i++) tx_pop();

    w1c(7'h7F);
    tx_pop();
    chk("R5 tx underrun flag", {31'b0, irq_sts_o[2]}, 32'h1);
    chk("R5 tx level", {25'b0, fifo_sts_o[6:0]}, 32'h0);
    w1c(7'h01);
    chk("R9 set wins over clear", {31'b0, irq_sts_o[0]}, 32'h1);
    chk("R9 unwritten bit kept", {31'b0, irq_sts_o[2]}, 32'h1);
    chk("R9 cleared bit stays", {31'b0, irq_sts_o[3]}, 32'h0);

    w1c(7'h7F);
    for (int i = 0; i < 3; i++) rx_push(8'h31 + 8'(i));
    step(4);
    chk("R8 trailing not yet", {31'b0, irq_sts_o[6]}, 32'h0);
    step(1);
    chk("R8 trailing set", {31'b0, irq_sts_o[6]}, 32'h1);

    rx_push(8'h34);
    step(1);
    chk("R7 rx almost-full", {31'b0, irq_sts_o[1]}, 32'h1);
    for (int i = 0; i < 4; i++) rx_pop();
    rx_pop();
    chk("R5 rx underrun flag", {31'b0, irq_sts_o[4]}, 32'h1);

    for (int i = 0; i < DEPTH; i++) rx_push(8'h40 + 8'(i));
    rx_push(8'hEE);
    chk("R4 rx overrun flag", {31'b0, irq_sts_o[5]}, 32'h1);
    chk("R11 rx fields", {23'b0, fifo_sts_o[24:16]}, 32'h090);

    irq_en_i = 7'h20;
    step(1);
    chk("R10 enabled source", {31'b0, irq_o}, 32'h1);
    w1c(7'h20);
    chk("R10 other bits masked", {31'b0, irq_o}, 32'h0);

    ctrl_i = 32'h0002_0042;
    step(1);
    rx_q.delete();
    chk("R3 rx flushed", {23'b0, fifo_sts_o[24:16]}, 32'h100);
    w1c(7'h7F);
    rx_push(8'h55);
    chk("R3 push ignored", {23'b0, fifo_sts_o[24:16]}, 32'h100);
    chk("R3 no overrun", {31'b0, irq_sts_o[5]}, 32'h0);
    ctrl_i = 32'h0002_0043;
    step(1);
    chk("R3 still empty", {23'b0, fifo_sts_o[24:16]}, 32'h100);
    rx_push(8'h66);
    rx_pop();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule